// File: doc/BRIEF.md
# Dragon Update-Protocol Cache Controller

This block is the coherence controller of a small direct-mapped write-back cache in a snooping multiprocessor. It uses an update protocol with four states. When a core writes a block that other caches also hold, the new word is broadcast to those caches instead of invalidating their copies. A line that has never been filled is marked absent, and any access to it misses. A present line is always in one of the four states. Lines are never invalidated; they are only replaced. Each line holds one data word.

The processor side uses a request/done handshake. The core holds `cpu_req` and its operands until `cpu_done` pulses for one cycle, and `cpu_rdata` is valid during that pulse. On the bus side the block acts as a master: it raises `bus_req` with a command and waits for `bus_gnt`. The fill word and the wired-OR shared line are sampled on the grant edge.

The snoop side receives the transactions of the other masters. For each one it answers in the same cycle with its contribution to the shared line and, when it owns the block, with supplied data. A snoop is never presented in the same cycle as this block's own grant. When a snoop and a new processor request arrive together, the snoop takes effect first, and the request is decided one cycle later against the updated line.

Top module: `dragon_cache`

## Requirements
- R1: After reset every line is absent, `cpu_done` and `bus_req` are low, and the first access to any line issues a bus read.
- R2: A read miss issues a bus read (command 2'b01) to the requested address. On the grant edge the line is filled in Shared-clean if `bus_shared` is high, otherwise in Exclusive-clean. `cpu_done` pulses in the cycle after the grant, carrying the fill word.
- R3: A read hit produces no bus request. `cpu_done` pulses in the second cycle after the request is seen, carrying the stored word.
- R4: A write hit in Exclusive-clean or Modified stores the word, leaves the line Modified and uses no bus transaction.
- R5: A write hit in Shared-clean or Shared-modified issues an update (command 2'b10) carrying the address and the new word. The local copy stays unchanged until the grant edge. At that edge the word is written, and the line becomes Shared-modified if `bus_shared` is high, Modified otherwise.
- R6: A write miss first issues a bus read. If the block is shared, the line is loaded Shared-modified and an update follows. If it is not shared, the line is loaded with the written word in Modified and no update is sent.
- R7: A miss that replaces a present Modified or Shared-modified line first issues a write-back (command 2'b11) with the victim's address and word, then the bus read. A clean victim is dropped silently.
- R8: A snooped bus read (command 2'b01) that hits raises `snp_shared`. An owner (Modified or Shared-modified) also raises `snp_supply` with its word and moves to Shared-modified. Exclusive-clean moves to Shared-clean, and Shared-clean stays put.
- R9: A snooped update (command 2'b10) that hits raises `snp_shared`, writes the broadcast word into the line and leaves it Shared-clean.
- R10: A snoop to an absent line or to a different tag asserts neither `snp_shared` nor `snp_supply` and changes nothing.
- R11: When a snoop and a processor request are presented in the same idle cycle, the snoop is applied first. The request is then served against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low bits index the line |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Word of the line at completion |
| bus_req | output | 1 | Bus-master request |
| bus_cmd | output | 2 | 01 read, 10 update, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Update or write-back word |
| bus_gnt | input | 1 | Grant; transaction completes on this edge |
| bus_rdata | input | DATA_W | Fill word, valid with grant |
| bus_shared | input | 1 | Wired-OR shared line, valid with grant |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | Contribution to the wired-OR shared line |
| snp_supply | output | 1 | This cache supplies the block |
| snp_sdata | output | DATA_W | Supplied word |

## Verification
The collision that matters is a snoop arriving in the same cycle as a processor request to the same line. The bench provokes it by presenting a snooped read together with a write to an Exclusive-clean line. The snoop must demote the line before the write is decided, so an update has to appear on the bus where a silent write would otherwise occur. The second collision is a snooped update landing while a local update waits for its grant. In that case the broadcast word is overwritten by the local word only at the grant. In both cases the cycle-accurate model in the bench decides the expected bus traffic, the returned words and the snoop responses.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

   typedef enum logic [1:0] {
      LS_EC = 2'd0,   // exclusive clean
      LS_SC = 2'd1,   // shared clean
      LS_SM = 2'd2,   // shared, owner, memory stale
      LS_MD = 2'd3    // exclusive, dirty
   } line_st_e;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_READ = 2'd1,
      BC_UPD  = 2'd2,
      BC_WB   = 2'd3
   } bus_cmd_e;

endpackage

// File: rtl/dragon_line_store.sv
module dragon_line_store
   import dragon_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   // local lookup
   input  logic [IDX_W-1:0]  la_idx,
   output logic              la_pres,
   output logic [TAG_W-1:0]  la_tag,
   output line_st_e          la_st,
   output logic [DATA_W-1:0] la_data,
   // snoop lookup
   input  logic [IDX_W-1:0]  sb_idx,
   output logic              sb_pres,
   output logic [TAG_W-1:0]  sb_tag,
   output line_st_e          sb_st,
   output logic [DATA_W-1:0] sb_data,
   // snoop write (state, optional word)
   input  logic              sw_en,
   input  line_st_e          sw_st,
   input  logic              sw_data_en,
   input  logic [DATA_W-1:0] sw_data,
   // local write (full line); wins over a snoop write to the same line
   input  logic              lw_en,
   input  logic [IDX_W-1:0]  lw_idx,
   input  logic [TAG_W-1:0]  lw_tag,
   input  line_st_e          lw_st,
   input  logic [DATA_W-1:0] lw_data
);

   logic [LINES-1:0]             pres_v;
   logic [LINES-1:0][TAG_W-1:0]  tag_v;
   logic [LINES-1:0][1:0]        st_v;
   logic [LINES-1:0][DATA_W-1:0] data_v;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic              pres_q;
      logic [TAG_W-1:0]  tag_q;
      line_st_e          st_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q <= 1'b0;
            tag_q  <= '0;
            st_q   <= LS_EC;
            data_q <= '0;
         end else if (lw_en && lw_idx == IDX_W'(g)) begin
            pres_q <= 1'b1;
            tag_q  <= lw_tag;
            st_q   <= lw_st;
            data_q <= lw_data;
         end else if (sw_en && sb_idx == IDX_W'(g)) begin
            st_q <= sw_st;
            if (sw_data_en) data_q <= sw_data;
         end
      end

      assign pres_v[g] = pres_q;
      assign tag_v[g]  = tag_q;
      assign st_v[g]   = st_q;
      assign data_v[g] = data_q;
   end

   assign la_pres = pres_v[la_idx];
   assign la_tag  = tag_v[la_idx];
   assign la_st   = line_st_e'(st_v[la_idx]);
   assign la_data = data_v[la_idx];

   assign sb_pres = pres_v[sb_idx];
   assign sb_tag  = tag_v[sb_idx];
   assign sb_st   = line_st_e'(st_v[sb_idx]);
   assign sb_data = data_v[sb_idx];

endmodule

// File: rtl/dragon_snoop.sv
module dragon_snoop
   import dragon_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  logic [DATA_W-1:0] snp_data,
   input  logic              sb_pres,
   input  logic [TAG_W-1:0]  sb_tag,
   input  line_st_e          sb_st,
   input  logic [DATA_W-1:0] sb_data,
   output logic              snp_shared,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_sdata,
   output logic              sw_en,
   output line_st_e          sw_st,
   output logic              sw_data_en,
   output logic [DATA_W-1:0] sw_data
);

   logic match, is_rd, is_upd, owner;

   assign match  = snp_valid && sb_pres && (sb_tag == snp_tag);
   assign is_rd  = match && (snp_cmd == BC_READ);
   assign is_upd = match && (snp_cmd == BC_UPD);
   assign owner  = (sb_st == LS_SM) || (sb_st == LS_MD);

   assign snp_shared = is_rd || is_upd;
   assign snp_supply = is_rd && owner;
   assign snp_sdata  = sb_data;

   assign sw_en      = is_rd || is_upd;
   assign sw_data_en = is_upd;
   assign sw_data    = snp_data;

   always_comb begin
      if (is_upd || !owner) sw_st = LS_SC;
      else                  sw_st = LS_SM;
   end

endmodule

// File: rtl/dragon_ctrl.sv
module dragon_ctrl
   import dragon_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32,
   localparam int ADDR_W = IDX_W + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              snp_valid,
   input  logic              la_pres,
   input  logic [TAG_W-1:0]  la_tag,
   input  line_st_e          la_st,
   input  logic [DATA_W-1:0] la_data,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_shared,
   output logic              lw_en,
   output logic [TAG_W-1:0]  lw_tag,
   output line_st_e          lw_st,
   output logic [DATA_W-1:0] lw_data
);

   typedef enum logic [2:0] {P_IDLE, P_EVICT, P_FILL, P_UPD, P_DONE} ph_e;

   ph_e               ph_q, ph_d;
   logic [DATA_W-1:0] rd_q, rd_d;
   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic              hit, dirty;

   assign idx   = cpu_addr[IDX_W-1:0];
   assign tag   = cpu_addr[ADDR_W-1:IDX_W];
   assign hit   = la_pres && (la_tag == tag);
   assign dirty = (la_st == LS_SM) || (la_st == LS_MD);

   always_comb begin
      ph_d      = ph_q;
      rd_d      = rd_q;
      lw_en     = 1'b0;
      lw_tag    = tag;
      lw_st     = la_st;
      lw_data   = la_data;
      bus_req   = 1'b0;
      bus_cmd   = BC_NONE;
      bus_addr  = cpu_addr;
      bus_wdata = cpu_wdata;
      cpu_done  = 1'b0;
      case (ph_q)
         P_IDLE: begin
            // a snoop this cycle goes first; the request is decided next cycle
            if (cpu_req && !snp_valid) begin
               if (hit) begin
                  if (!cpu_we) begin
                     rd_d = la_data;
                     ph_d = P_DONE;
                  end else if (la_st == LS_EC || la_st == LS_MD) begin
                     lw_en   = 1'b1;
                     lw_st   = LS_MD;
                     lw_data = cpu_wdata;
                     rd_d    = cpu_wdata;
                     ph_d    = P_DONE;
                  end else begin
                     ph_d = P_UPD;
                  end
               end else if (la_pres && dirty) begin
                  ph_d = P_EVICT;
               end else begin
                  ph_d = P_FILL;
               end
            end
         end
         P_EVICT: begin
            bus_req   = 1'b1;
            bus_cmd   = BC_WB;
            bus_addr  = {la_tag, idx};
            bus_wdata = la_data;
            if (bus_gnt) ph_d = P_FILL;
         end
         P_FILL: begin
            bus_req = 1'b1;
            bus_cmd = BC_READ;
            if (bus_gnt) begin
               lw_en   = 1'b1;
               lw_data = bus_rdata;
               if (!cpu_we) begin
                  lw_st = bus_shared ? LS_SC : LS_EC;
                  rd_d  = bus_rdata;
                  ph_d  = P_DONE;
               end else if (bus_shared) begin
                  lw_st = LS_SM;
                  ph_d  = P_UPD;
               end else begin
                  lw_st   = LS_MD;
                  lw_data = cpu_wdata;
                  rd_d    = cpu_wdata;
                  ph_d    = P_DONE;
               end
            end
         end
         P_UPD: begin
            bus_req = 1'b1;
            bus_cmd = BC_UPD;
            if (bus_gnt) begin
               lw_en   = 1'b1;
               lw_st   = bus_shared ? LS_SM : LS_MD;
               lw_data = cpu_wdata;
               rd_d    = cpu_wdata;
               ph_d    = P_DONE;
            end
         end
         P_DONE: begin
            cpu_done = 1'b1;
            ph_d     = P_IDLE;
         end
         default: ph_d = P_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= P_IDLE;
         rd_q <= '0;
      end else begin
         ph_q <= ph_d;
         rd_q <= rd_d;
      end
   end

   assign cpu_rdata = rd_q;

endmodule

// File: rtl/dragon_cache.sv
module dragon_cache
   import dragon_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_shared,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [DATA_W-1:0] snp_data,
   output logic              snp_shared,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_sdata
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("dragon_cache: LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("dragon_cache: ADDR_W must leave at least one tag bit");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dragon_cache: DATA_W must be positive");
   end

   logic              la_pres, sb_pres;
   logic [TAG_W-1:0]  la_tag, sb_tag;
   line_st_e          la_st, sb_st;
   logic [DATA_W-1:0] la_data, sb_data;
   logic              sw_en, sw_data_en;
   line_st_e          sw_st;
   logic [DATA_W-1:0] sw_data;
   logic              lw_en;
   logic [TAG_W-1:0]  lw_tag;
   line_st_e          lw_st;
   logic [DATA_W-1:0] lw_data;

   dragon_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .la_idx     (cpu_addr[IDX_W-1:0]),
      .la_pres    (la_pres),
      .la_tag     (la_tag),
      .la_st      (la_st),
      .la_data    (la_data),
      .sb_idx     (snp_addr[IDX_W-1:0]),
      .sb_pres    (sb_pres),
      .sb_tag     (sb_tag),
      .sb_st      (sb_st),
      .sb_data    (sb_data),
      .sw_en      (sw_en),
      .sw_st      (sw_st),
      .sw_data_en (sw_data_en),
      .sw_data    (sw_data),
      .lw_en      (lw_en),
      .lw_idx     (cpu_addr[IDX_W-1:0]),
      .lw_tag     (lw_tag),
      .lw_st      (lw_st),
      .lw_data    (lw_data)
   );

   dragon_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_valid  (snp_valid),
      .snp_cmd    (snp_cmd),
      .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
      .snp_data   (snp_data),
      .sb_pres    (sb_pres),
      .sb_tag     (sb_tag),
      .sb_st      (sb_st),
      .sb_data    (sb_data),
      .snp_shared (snp_shared),
      .snp_supply (snp_supply),
      .snp_sdata  (snp_sdata),
      .sw_en      (sw_en),
      .sw_st      (sw_st),
      .sw_data_en (sw_data_en),
      .sw_data    (sw_data)
   );

   dragon_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_done   (cpu_done),
      .cpu_rdata  (cpu_rdata),
      .snp_valid  (snp_valid),
      .la_pres    (la_pres),
      .la_tag     (la_tag),
      .la_st      (la_st),
      .la_data    (la_data),
      .bus_req    (bus_req),
      .bus_cmd    (bus_cmd),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_gnt    (bus_gnt),
      .bus_rdata  (bus_rdata),
      .bus_shared (bus_shared),
      .lw_en      (lw_en),
      .lw_tag     (lw_tag),
      .lw_st      (lw_st),
      .lw_data    (lw_data)
   );

endmodule

// File: rtl/dragon_cache_chk.sv
module dragon_cache_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_done,
   input logic              bus_req,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_gnt,
   input logic              bus_shared,
   input logic              snp_valid,
   input logic              snp_shared,
   input logic              snp_supply,
   input logic [DATA_W-1:0] la_data
);

   // R1: completion is a single-cycle pulse
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R2: a read fill is followed directly by completion
   a_r2_fill_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'b01 && bus_gnt && !cpu_we) |=> cpu_done);

   // R5: a waiting update keeps address and word steady
   a_r5_upd_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'b10 && !bus_gnt) |=>
         (bus_req && bus_cmd == 2'b10 && $stable(bus_addr) && $stable(bus_wdata)));

   // R5: no local write before the update is granted
   a_r5_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'b10 && !bus_gnt && !snp_valid) |=>
         ($stable(la_data) || !$stable(cpu_addr)));

   // R6: a shared write fill is followed by an update
   a_r6_fill_then_upd: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'b01 && bus_gnt && cpu_we && bus_shared) |=>
         (bus_req && bus_cmd == 2'b10));

   // R7: a write-back is followed by the bus read
   a_r7_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'b11 && bus_gnt) |=> (bus_req && bus_cmd == 2'b01));

   // R8: supplying implies sharing
   a_r8_supply_shared: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> snp_shared);

   // R10: without a snoop there is no snoop response
   a_r10_quiet_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid |-> (!snp_shared && !snp_supply));

endmodule

bind dragon_cache dragon_cache_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_we     (cpu_we),
   .cpu_addr   (cpu_addr),
   .cpu_done   (cpu_done),
   .bus_req    (bus_req),
   .bus_cmd    (bus_cmd),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_gnt    (bus_gnt),
   .bus_shared (bus_shared),
   .snp_valid  (snp_valid),
   .snp_shared (snp_shared),
   .snp_supply (snp_supply),
   .la_data    (la_data)
);

// File: tb/sim_dragon_cache.sv
`timescale 1ns/100ps
module sim_dragon_cache;

   localparam int NL = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        bus_req;
   logic [1:0]  bus_cmd;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_gnt = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        bus_shared = 1'b0;
   logic        snp_valid = 1'b0;
   logic [1:0]  snp_cmd = '0;
   logic [7:0]  snp_addr = '0;
   logic [31:0] snp_data = '0;
   logic        snp_shared, snp_supply;
   logic [31:0] snp_sdata;

   always #2 clk = ~clk;   // 250 MHz

   dragon_cache u0 (.*);

   int    vectors = 0, miscompares = 0;
   string tag = "R1";
   bit    sh_knob = 1'b0;
   int    gdly = 0;
   bit    started = 1'b0;

   function automatic logic [31:0] mem_f(logic [7:0] a);
      return 32'h5A00_0000 + {24'd0, a} * 32'h0001_0103;
   endfunction

   // ---------------- reference model (states: 0 EC, 1 SC, 2 SM, 3 MD) ----
   bit          mp[NL];
   logic [3:0]  mt[NL];
   int          ms[NL];
   logic [31:0] md[NL];
   int          mph = 0;     // 0 idle, 1 write-back, 2 fill, 3 update, 4 done
   logic [31:0] mrd = '0;

   always @(posedge clk) begin
      int li, si, nph, lst;
      bit lw, lhit;
      logic [3:0] lt;
      logic [31:0] ldat, nrd;
      started = 1'b1;
      if (!rst_n) begin
         for (int k = 0; k < NL; k++) begin mp[k] = 0; mt[k] = 0; ms[k] = 0; md[k] = 0; end
         mph = 0; mrd = 0;
      end else begin
         li = int'(cpu_addr[3:0]); lt = cpu_addr[7:4];
         lhit = mp[li] && mt[li] == lt;
         nph = mph; lw = 0; lst = 0; ldat = 0; nrd = mrd;
         case (mph)
            0: if (cpu_req && !snp_valid) begin
                  if (lhit && !cpu_we) begin nrd = md[li]; nph = 4; end
                  else if (lhit && (ms[li] == 0 || ms[li] == 3)) begin
                     lw = 1; lst = 3; ldat = cpu_wdata; nrd = cpu_wdata; nph = 4;
                  end else if (lhit) nph = 3;
                  else nph = (mp[li] && ms[li] >= 2) ? 1 : 2;
               end
            1: if (bus_gnt) nph = 2;
            2: if (bus_gnt) begin
                  lw = 1;
                  if (!cpu_we) begin lst = bus_shared ? 1 : 0; ldat = bus_rdata; nrd = bus_rdata; nph = 4; end
                  else if (bus_shared) begin lst = 2; ldat = bus_rdata; nph = 3; end
                  else begin lst = 3; ldat = cpu_wdata; nrd = cpu_wdata; nph = 4; end
               end
            3: if (bus_gnt) begin
                  lw = 1; lst = bus_shared ? 2 : 3; ldat = cpu_wdata; nrd = cpu_wdata; nph = 4;
               end
            default: nph = 0;
         endcase
         si = int'(snp_addr[3:0]);
         if (snp_valid && mp[si] && mt[si] == snp_addr[7:4]) begin
            if (snp_cmd == 2'b01) ms[si] = (ms[si] >= 2) ? 2 : 1;
            else if (snp_cmd == 2'b10) begin ms[si] = 1; md[si] = snp_data; end
         end
         if (lw) begin mp[li] = 1; mt[li] = lt; ms[li] = lst; md[li] = ldat; end
         mph = nph; mrd = nrd;
      end
   end

   task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int i, si;
      bit e_req, shit;
      logic [1:0] e_cmd;
      if (started) begin
         vectors++;
         i = int'(cpu_addr[3:0]);
         e_req = (mph >= 1 && mph <= 3);
         e_cmd = (mph == 1) ? 2'b11 : (mph == 2) ? 2'b01 : (mph == 3) ? 2'b10 : 2'b00;
         cmp("cpu_done", {31'd0, cpu_done}, {31'd0, mph == 4});
         if (mph == 4) cmp("cpu_rdata", cpu_rdata, mrd);
         cmp("bus_req", {31'd0, bus_req}, {31'd0, e_req});
         if (e_req) begin
            cmp("bus_cmd", {30'd0, bus_cmd}, {30'd0, e_cmd});
            cmp("bus_addr", {24'd0, bus_addr}, (mph == 1) ? {24'd0, mt[i], cpu_addr[3:0]} : {24'd0, cpu_addr});
            if (mph != 2) cmp("bus_wdata", bus_wdata, (mph == 1) ? md[i] : cpu_wdata);
         end
         si = int'(snp_addr[3:0]);
         shit = snp_valid && mp[si] && mt[si] == snp_addr[7:4] &&
                (snp_cmd == 2'b01 || snp_cmd == 2'b10);
         cmp("snp_shared", {31'd0, snp_shared}, {31'd0, shit});
         cmp("snp_supply", {31'd0, snp_supply}, {31'd0, shit && snp_cmd == 2'b01 && ms[si] >= 2});
         if (shit && snp_cmd == 2'b01 && ms[si] >= 2) cmp("snp_sdata", snp_sdata, md[si]);
      end
   end

   // ---------------- bus responder ----------------
   initial begin
      int wcnt;
      wcnt = 0;
      forever begin
         @(posedge clk); #1;
         if (bus_req && !snp_valid && wcnt == 0) begin
            bus_gnt = 1; bus_rdata = mem_f(bus_addr); bus_shared = sh_knob; wcnt = gdly;
         end else begin
            bus_gnt = 0;
            if (!bus_req) wcnt = gdly;
            else if (wcnt > 0) wcnt--;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic op(bit we, logic [7:0] a, logic [31:0] d);
      @(posedge clk); #0.5;
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      forever begin
         @(negedge clk);
         if (cpu_done) break;
      end
      cpu_req = 0;
   endtask

   task automatic snoop(logic [1:0] c, logic [7:0] a, logic [31:0] d);
      @(posedge clk); #0.5;
      snp_valid = 1; snp_cmd = c; snp_addr = a; snp_data = d;
      @(posedge clk); #0.5;
      snp_valid = 0;
   endtask

   task automatic expect_val(string req, logic [7:0] a, logic [31:0] exp);
      op(0, a, 32'd0);
      #0.1;
      if (cpu_rdata !== exp) begin
         miscompares++;
         $display("FAIL %s readback %h: actual %h expected %h", req, a, cpu_rdata, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not end");
      finish_run();
   end

   initial begin
      tag = "R1";
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1;
      repeat (3) @(posedge clk);
      op(0, 8'h01, 0);                       // first access must miss
      tag = "R2";
      sh_knob = 0; op(0, 8'h03, 0);          // -> EC
      sh_knob = 1; op(0, 8'h04, 0);          // -> SC
      expect_val("R2", 8'h03, mem_f(8'h03));
      tag = "R3";
      op(0, 8'h03, 0); op(0, 8'h04, 0);
      tag = "R4";
      sh_knob = 0;
      op(1, 8'h03, 32'h1111_0003);           // EC -> MD silently
      op(1, 8'h03, 32'h2222_0003);           // MD stays
      expect_val("R4", 8'h03, 32'h2222_0003);
      tag = "R5";
      gdly = 3; sh_knob = 1;
      op(1, 8'h04, 32'h3333_0004);           // SC -> update -> SM
      sh_knob = 0;
      op(1, 8'h04, 32'h4444_0004);           // SM -> update -> MD
      op(1, 8'h04, 32'h5555_0004);           // MD silent
      gdly = 1;
      tag = "R6";
      sh_knob = 1; op(1, 8'h15, 32'h6666_0015);   // read then update -> SM
      sh_knob = 0; op(1, 8'h26, 32'h7777_0026);   // read only -> MD
      sh_knob = 1; op(1, 8'h35, 32'h7878_0035);   // evict SM, read, update
      tag = "R7";
      sh_knob = 0;
      op(0, 8'h13, 0);                       // evicts MD line 0x03
      op(0, 8'h24, 0);                       // evicts MD line 0x04
      op(0, 8'h34, 0);                       // EC victim, dropped
      op(0, 8'h45, 0);                       // evicts SM line 0x35
      tag = "R8";
      op(1, 8'h15, 32'h8888_0015);           // line 5 -> MD
      snoop(2'b01, 8'h15, 0);                // owner supplies, -> SM
      snoop(2'b01, 8'h26, 0);                // MD supplies, -> SM
      op(0, 8'h07, 0);                       // EC
      snoop(2'b01, 8'h07, 0);                // EC -> SC
      op(1, 8'h07, 32'h9999_0007);           // must now update
      snoop(2'b01, 8'h34, 0);                // EC -> SC, no supply
      snoop(2'b01, 8'h34, 0);                // SC stays
      tag = "R9";
      snoop(2'b10, 8'h15, 32'hABCD_0015);
      expect_val("R9", 8'h15, 32'hABCD_0015);
      snoop(2'b01, 8'h15, 0);                // SC, no supply
      tag = "R10";
      snoop(2'b01, 8'h55, 0);                // tag mismatch
      snoop(2'b10, 8'h5A, 32'hDEAD_BEEF);    // absent line
      snoop(2'b11, 8'h15, 32'hDEAD_0001);    // write-back command: no reaction
      expect_val("R10", 8'h15, 32'hABCD_0015);
      tag = "R11";
      sh_knob = 0;
      op(0, 8'h08, 0);                       // EC
      fork
         op(1, 8'h08, 32'hC0C0_0008);
         snoop(2'b01, 8'h08, 0);
      join                                   // snoop demotes, write updates
      gdly = 4; sh_knob = 1;
      snoop(2'b01, 8'h08, 0);                // MD -> SM
      fork
         op(1, 8'h08, 32'hC1C1_0008);
         begin repeat (2) @(posedge clk); snoop(2'b10, 8'h08, 32'hFEED_0008); end
      join
      expect_val("R11", 8'h08, 32'hC1C1_0008);
      gdly = 0;
      fork
         op(0, 8'h07, 0);
         snoop(2'b10, 8'h07, 32'h0BAD_0007);
      join
      expect_val("R11", 8'h07, 32'h0BAD_0007);
      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule